// File: doc/BRIEF.md
# PLL-initialization clock override controller

This block keeps the configuration word of a clock-alignment unit and turns it into the live control signals for that unit: the select shared by the four aligned-clock glitch-free multiplexers, the standby multiplexer select, the PLL reference select, the PLL bypass control, the DDR clock gate enable and the first-stage divisor code. The multiplexers, dividers and PLL themselves sit outside. The block only drives their controls.

Its central feature is a PLL-initialization override bit. While that bit is set, every select, the bypass control and the DDR gate take fixed safe values. The aligned clocks run from the standby clock, the standby clock comes from the internal RC oscillator, the PLL reference comes from the fabric base clock, bypass is off and the DDR clock is gated. The override bit comes out of reset set. Taking it from 0 to 1 raises a sticky interrupt to a supervisory controller. That controller waits for PLL lock, clears the bit, and so returns the clocks to their run-time sources. The block also produces the controller reset. A persist bit chooses whether that reset follows every system reset or only power-on reset. The PLL reset output is the inverse of the controller reset.

Top module: `pllinit_clkctl`

Configuration word layout (bit positions used by the write port): bit 0 override, bit 1 reference select (1 = fabric clock, 0 = RC 50 MHz), bit 2 standby select (1 = RC oscillator), bit 3 PLL bypass, bit 4 aligned-mux select (1 = standby clock, 0 = divider outputs), bit 5 DDR clock enable (1 = pass, 0 = gated), bits 7:6 first-stage divisor (00 = 1:1, 01 = 2:1, 10 = 3:1, 11 reserved), bit 8 persist. All other bits are ignored.

## Requirements
- R1: After reset the override is active, so align_stby_o=1, stby_rc_o=1, ref_fab_o=1, pll_bypass_o=0, ddr_clk_en_o=0, stage_a_div_o=00 and irq_o=0.
- R2: While the override is active, align_stby_o=1, stby_rc_o=1, ref_fab_o=1, pll_bypass_o=0 and ddr_clk_en_o=0 whatever the run-time fields hold.
- R3: While the override is inactive, the five control outputs equal the run-time fields (bits 1 to 5), and they update the cycle after a write.
- R4: The static fields (aligned-mux select bit 4, DDR enable bit 5, divisor bits 7:6, persist bit 8) accept writes only while the override is active. A write while it is inactive leaves them unchanged.
- R5: A write of divisor code 11 leaves the previous divisor unchanged. Codes 00, 01 and 10 are stored.
- R6: irq_o rises the cycle after a write that takes the override bit from 0 to 1. Reset, or a write of 1 when the bit is already 1, does not raise it.
- R7: irq_o stays set until irq_ack is pulsed, and it clears the cycle after the pulse. A new set in the same cycle as an acknowledge wins.
- R8: A write that clears the override bit takes effect only while pll_lock is 1. Otherwise the override stays active.
- R9: pll_rst_o is always the inverse of cc_rst_n_o. cc_rst_n_o is low during power-on reset, and also during system reset when persist is 0.
- R10: The persist bit keeps its value through a system reset and is cleared only by power-on reset. A system reset returns all other fields and the interrupt to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | CFG_W | Configuration word to write |
| irq_ack | input | 1 | Write-one-to-clear acknowledge of the interrupt |
| pll_lock | input | 1 | PLL lock indication |
| align_stby_o | output | 1 | Aligned-mux select, 1 = standby clock |
| stby_rc_o | output | 1 | Standby mux select, 1 = RC oscillator |
| ref_fab_o | output | 1 | Reference mux select, 1 = fabric base clock |
| pll_bypass_o | output | 1 | PLL bypass enable |
| ddr_clk_en_o | output | 1 | DDR clock gate enable, 1 = pass |
| stage_a_div_o | output | 2 | First-stage divisor code |
| irq_o | output | 1 | Sticky interrupt to supervisory controller |
| cc_rst_n_o | output | 1 | Controller reset, active low |
| pll_rst_o | output | 1 | PLL reset, active high |

## Verification
The bench sweeps every combination of run-time and static fields with the override both set and clear. An override mux that leaked a field would show a live select while the PLL is unlocked, and a missing static write guard would let the DDR gate or divisor change in run mode. The bench writes the reserved divisor code between legal codes, which catches a design that stores it. It clears the override with lock low, which catches a design that drops to the PLL clocks before lock. The interrupt cases cover a write of 1 over 1, an acknowledge in the same cycle as a new set, and reset. A design that detected the level rather than the edge, or gave the acknowledge priority, would then show the wrong irq_o. The bench applies system and power-on resets with persist both ways and observes cc_rst_n_o. A design that reset persist on system reset, or ignored persist, would show the wrong controller reset.

// File: rtl/pllinit_pkg.sv
package pllinit_pkg;
  localparam int CFG_W = 16;
  localparam int DIV_W = 2;
  localparam logic [DIV_W-1:0] DIV_RSVD = 2'b11;

  typedef struct packed {
    logic             persist;
    logic [DIV_W-1:0] pre_div;
    logic             ddr_en;
    logic             align_stby;
    logic             bypass;
    logic             stby_rc;
    logic             ref_fab;
    logic             ovr;
  } cfg_t;

  localparam int FIELD_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{persist: 1'b0, pre_div: '0, ddr_en: 1'b0,
                                 align_stby: 1'b0, bypass: 1'b0, stby_rc: 1'b0,
                                 ref_fab: 1'b0, ovr: 1'b1};
endpackage

// File: rtl/pllinit_rst_sync.sv
module pllinit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/pllinit_cfg_regs.sv
module pllinit_cfg_regs
  import pllinit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic por_rst_n,
  input  logic wr_en,
  input  cfg_t wr_cfg,
  input  logic pll_lock,
  output cfg_t cfg_q,
  output logic ovr_rise_o
);
  cfg_t cfg_d;
  logic persist_q;
  logic persist_d;
  cfg_t main_q;

  always_comb begin
    cfg_d     = main_q;
    persist_d = persist_q;
    if (wr_en) begin
      cfg_d.ref_fab = wr_cfg.ref_fab;
      cfg_d.stby_rc = wr_cfg.stby_rc;
      cfg_d.bypass  = wr_cfg.bypass;
      if (wr_cfg.ovr || pll_lock) cfg_d.ovr = wr_cfg.ovr;
      if (main_q.ovr) begin
        cfg_d.align_stby = wr_cfg.align_stby;
        cfg_d.ddr_en     = wr_cfg.ddr_en;
        persist_d        = wr_cfg.persist;
        if (wr_cfg.pre_div != DIV_RSVD) cfg_d.pre_div = wr_cfg.pre_div;
      end
    end
    cfg_d.persist = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) main_q <= CFG_RESET;
    else        main_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) persist_q <= 1'b0;
    else            persist_q <= persist_d;
  end

  always_comb begin
    cfg_q         = main_q;
    cfg_q.persist = persist_q;
  end

  assign ovr_rise_o = cfg_d.ovr & ~main_q.ovr;
endmodule

// File: rtl/pllinit_irq.sv
module pllinit_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (ack_i) irq_d = 1'b0;
    if (set_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pllinit_out_mux.sv
module pllinit_out_mux
  import pllinit_pkg::*;
(
  input  cfg_t             cfg,
  output logic             align_stby_o,
  output logic             stby_rc_o,
  output logic             ref_fab_o,
  output logic             pll_bypass_o,
  output logic             ddr_clk_en_o,
  output logic [DIV_W-1:0] stage_a_div_o
);
  localparam logic [4:0] SAFE_CTRL = 5'b11100;
  logic [4:0] run_ctrl;
  logic [4:0] sel_ctrl;

  assign run_ctrl = {cfg.align_stby, cfg.stby_rc, cfg.ref_fab, cfg.bypass, cfg.ddr_en};

  always_comb begin
    if (cfg.ovr) sel_ctrl = SAFE_CTRL;
    else         sel_ctrl = run_ctrl;
  end

  assign {align_stby_o, stby_rc_o, ref_fab_o, pll_bypass_o, ddr_clk_en_o} = sel_ctrl;
  assign stage_a_div_o = cfg.pre_div;
endmodule

// File: rtl/pllinit_clkctl.sv
module pllinit_clkctl
  import pllinit_pkg::*;
#(
  parameter int CFG_W       = pllinit_pkg::CFG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             irq_ack,
  input  logic             pll_lock,
  output logic             align_stby_o,
  output logic             stby_rc_o,
  output logic             ref_fab_o,
  output logic             pll_bypass_o,
  output logic             ddr_clk_en_o,
  output logic [DIV_W-1:0] stage_a_div_o,
  output logic             irq_o,
  output logic             cc_rst_n_o,
  output logic             pll_rst_o
);
  logic por_s_n;
  logic sys_s_n;
  logic all_rst_n;
  cfg_t wr_cfg;
  cfg_t cfg_q;
  logic ovr_rise;
  logic ovr_q;

  pllinit_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n_o(por_s_n));

  pllinit_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst_n(sys_rst_n), .rst_n_o(sys_s_n));

  assign all_rst_n = por_s_n & sys_s_n;
  assign wr_cfg    = cfg_t'(wr_data[FIELD_W-1:0]);

  pllinit_cfg_regs u_regs (
    .clk(clk), .rst_n(all_rst_n), .por_rst_n(por_s_n), .wr_en(wr_en),
    .wr_cfg(wr_cfg), .pll_lock(pll_lock), .cfg_q(cfg_q), .ovr_rise_o(ovr_rise));

  pllinit_irq u_irq (
    .clk(clk), .rst_n(all_rst_n), .set_i(ovr_rise), .ack_i(irq_ack), .irq_o(irq_o));

  pllinit_out_mux u_mux (
    .cfg(cfg_q), .align_stby_o(align_stby_o), .stby_rc_o(stby_rc_o),
    .ref_fab_o(ref_fab_o), .pll_bypass_o(pll_bypass_o),
    .ddr_clk_en_o(ddr_clk_en_o), .stage_a_div_o(stage_a_div_o));

  assign ovr_q      = cfg_q.ovr;
  assign cc_rst_n_o = por_s_n & (sys_s_n | cfg_q.persist);
  assign pll_rst_o  = ~cc_rst_n_o;
endmodule

// File: rtl/pllinit_clkctl_chk.sv
module pllinit_clkctl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       ovr,
  input logic       pll_lock,
  input logic       irq_ack,
  input logic       irq_o,
  input logic       align_stby_o,
  input logic       stby_rc_o,
  input logic       ref_fab_o,
  input logic       pll_bypass_o,
  input logic       ddr_clk_en_o,
  input logic [1:0] stage_a_div_o
);
  // R2
  safe_ctrl_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    ovr |-> (align_stby_o && stby_rc_o && ref_fab_o && !pll_bypass_o && !ddr_clk_en_o));

  // R4
  static_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!$past(ovr) && !ovr) |-> $stable(stage_a_div_o));

  // R5
  no_rsvd_div_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    stage_a_div_o != 2'b11);

  // R6
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $rose(ovr) |-> irq_o);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    ($past(irq_o) && !$past(irq_ack)) |-> irq_o);

  // R8
  clear_locked_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $fell(ovr) |-> $past(pll_lock));
endmodule

bind pllinit_clkctl pllinit_clkctl_chk chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ovr(ovr_q),
  .pll_lock(pll_lock), .irq_ack(irq_ack), .irq_o(irq_o),
  .align_stby_o(align_stby_o), .stby_rc_o(stby_rc_o), .ref_fab_o(ref_fab_o),
  .pll_bypass_o(pll_bypass_o), .ddr_clk_en_o(ddr_clk_en_o),
  .stage_a_div_o(stage_a_div_o));

// File: tb/pllinit_clkctl_tb_top.sv
`timescale 1ns/1ps
module pllinit_clkctl_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_ack = 1'b0;
  logic        pll_lock = 1'b0;
  logic        align_stby_o, stby_rc_o, ref_fab_o, pll_bypass_o, ddr_clk_en_o;
  logic [1:0]  stage_a_div_o;
  logic        irq_o, cc_rst_n_o, pll_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pllinit_clkctl dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .irq_ack(irq_ack), .pll_lock(pll_lock),
    .align_stby_o(align_stby_o), .stby_rc_o(stby_rc_o), .ref_fab_o(ref_fab_o),
    .pll_bypass_o(pll_bypass_o), .ddr_clk_en_o(ddr_clk_en_o),
    .stage_a_div_o(stage_a_div_o), .irq_o(irq_o), .cc_rst_n_o(cc_rst_n_o),
    .pll_rst_o(pll_rst_o));

  function automatic logic [15:0] mk(logic ov, logic rf, logic sb, logic by,
                                     logic al, logic dd, logic [1:0] dv, logic ps);
    return {7'b0, ps, dv, dd, al, by, sb, rf, ov};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // control outputs packed as {align, stby, ref, bypass, ddr}
  task automatic chk_ctl(string tag, logic [4:0] exp);
    chk(tag, {3'b0, align_stby_o, stby_rc_o, ref_fab_o, pll_bypass_o, ddr_clk_en_o},
        {3'b0, exp});
  endtask

  task automatic wr(logic [15:0] d, logic ack);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; irq_ack = ack;
    @(negedge clk);
    wr_en = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sys;
    @(negedge clk); sys_rst_n = 1'b0; #1;
  endtask

  task automatic release_all;
    @(negedge clk); sys_rst_n = 1'b1; por_n = 1'b1;
    idle(4);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R9 por cc_rst_n", {7'b0, cc_rst_n_o}, 8'h0);
    chk("R9 por pll_rst", {7'b0, pll_rst_o}, 8'h1);
    release_all();
    // R1 reset state
    chk_ctl("R1 ctl", 5'b11100);
    chk("R1 div", {6'b0, stage_a_div_o}, 8'h0);
    chk("R1 irq", {7'b0, irq_o}, 8'h0);
    chk("R9 run cc_rst_n", {7'b0, cc_rst_n_o}, 8'h1);

    // R2 sweep of fields under override; static writes accepted (R4)
    for (int k = 0; k < 64; k++) begin
      logic [1:0] dv;
      dv = k[5] ? 2'b10 : 2'b01;
      wr(mk(1'b1, k[0], k[1], k[2], k[3], k[4], dv, 1'b0), 1'b0);
      chk_ctl("R2 forced", 5'b11100);
      chk("R4 div accepted in override", {6'b0, stage_a_div_o}, {6'b0, dv});
      chk("R6 no irq on 1 over 1", {7'b0, irq_o}, 8'h0);
    end

    // static setup: align=0, ddr=1, div=01, persist=0
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0), 1'b0);
    // R8 clear without lock is refused
    pll_lock = 1'b0;
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0), 1'b0);
    chk_ctl("R8 no lock still forced", 5'b11100);
    pll_lock = 1'b1;
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0), 1'b0);
    chk_ctl("R8 locked clear -> R3 run", 5'b00001);

    // R3 sweep of run-time fields; static field writes blocked (R4)
    for (int j = 0; j < 8; j++) begin
      logic [2:0] b;
      b = j[2:0];
      wr(mk(1'b0, b[0], b[1], b[2], 1'b1, 1'b0, 2'b10, 1'b1), 1'b0);
      chk_ctl("R3 follow / R4 static hold", {1'b0, b[1], b[0], b[2], 1'b1});
      chk("R4 div blocked", {6'b0, stage_a_div_o}, 8'h1);
    end
    // R4 persist write was blocked: system reset still resets controller
    pulse_sys();
    chk("R4 persist blocked", {7'b0, cc_rst_n_o}, 8'h0);
    chk("R9 pll_rst inverse", {7'b0, pll_rst_o}, 8'h1);
    release_all();
    chk_ctl("R10 sys reset restores override", 5'b11100);

    // R6 / R7 interrupt handshake
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
    chk("R6 no irq on clear", {7'b0, irq_o}, 8'h0);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
    chk("R6 irq on rise", {7'b0, irq_o}, 8'h1);
    idle(3);
    chk("R7 irq sticky", {7'b0, irq_o}, 8'h1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 ack clears", {7'b0, irq_o}, 8'h0);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
    chk("R6 1 over 1 no irq", {7'b0, irq_o}, 8'h0);
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b1);
    chk("R7 set wins over ack", {7'b0, irq_o}, 8'h1);

    // R5 reserved divisor code
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0), 1'b0);
    chk("R5 div 10", {6'b0, stage_a_div_o}, 8'h2);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0), 1'b0);
    chk("R5 div 11 ignored", {6'b0, stage_a_div_o}, 8'h2);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0);
    chk("R5 div 00", {6'b0, stage_a_div_o}, 8'h0);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0), 1'b0);
    chk("R5 div 11 after 00", {6'b0, stage_a_div_o}, 8'h0);
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0), 1'b0);
    chk("R5 div 01", {6'b0, stage_a_div_o}, 8'h1);

    // R9 / R10 persist behaviour
    wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1), 1'b0);
    pulse_sys();
    chk("R9 persist=1 sys reset cc", {7'b0, cc_rst_n_o}, 8'h1);
    chk("R9 persist=1 pll_rst", {7'b0, pll_rst_o}, 8'h0);
    release_all();
    chk("R10 div reset by sys", {6'b0, stage_a_div_o}, 8'h0);
    chk("R10 irq reset by sys", {7'b0, irq_o}, 8'h0);
    pulse_sys();
    chk("R10 persist kept", {7'b0, cc_rst_n_o}, 8'h1);
    release_all();
    @(negedge clk); por_n = 1'b0; #1;
    chk("R9 por overrides persist", {7'b0, cc_rst_n_o}, 8'h0);
    chk("R9 por pll_rst", {7'b0, pll_rst_o}, 8'h1);
    release_all();
    pulse_sys();
    chk("R10 persist cleared by por", {7'b0, cc_rst_n_o}, 8'h0);
    release_all();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule